// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write SRAM

This block is a single-port synchronous memory with pipelined reads. Each word has four byte lanes, and each lane carries eight data bits and one parity bit. Every control, address and data input is captured on the rising clock edge. Read data comes out through an output register. The shared data bus is split into three parts:
- a write-data input bus;
- a registered read-data output bus;
- a drive-enable output, which a pad ring or bus wrapper uses to steer the bidirectional pins.

A cycle can be started by either of two address strobes:
- A **processor-side strobe** always opens with a read. It can then turn into a write on the following edge.
- A **controller-side strobe** performs its write on the same edge when write controls are present.

While the device stays selected and no strobe arrives, each edge continues the access. The address comes from a two-bit wraparound burst counter that can advance on each such edge. The counter steps in linear or interleaved order.

Top module: `sbw_sram`

## Requirements
- R1: A synchronous active-high reset clears the read-data register to zero and turns drive-enable off. It leaves the device deselected.
- R2: Read data for an address issued at rising edge n is on `rdata_o` after edge n+1. The register changes only after an edge whose previous edge issued a read.
- R3: A read is issued when a recognized strobe, all three chip enables active, and no write control active occur together. No write control active means global write high and either byte-write enable high or all lane selects high. A controller-strobe cycle with byte-write enable high and lane selects low is a read.
- R4: A processor-strobe cycle is always a read of the captured address. Its global write, byte-write and advance inputs are ignored. When write controls are present on the next edge (no strobe), that edge writes with the data on that edge.
- R5: A controller-strobe cycle needs the processor strobe high, or the processor strobe ignored. When write controls are active, it writes the captured address on that same edge and ignores advance. With both strobes low and `en0_n` low, the processor strobe wins.
- R6: Global write low (`wr_all_n`=0) writes all four lanes regardless of `wr_lane_en_n` and `lane_sel_n`.
- R7: With global write high, lane k is written only when `wr_lane_en_n`=0 and `lane_sel_n[k]`=0. Other lanes keep their contents. Lane k is data bits [8k+7:8k] plus parity bit 32+k of the 36-bit bus.
- R8: `drive_en_o` is the internal live flag AND NOT `oe_n`, with no clock in the `oe_n` path.
- R9: A read issued from the deselected state keeps drive-enable off for the cycle after that edge, whatever `oe_n` is.
- R10: Any edge that performs a write turns drive-enable off for the following cycle, whatever `oe_n` is.
- R11: A recognized strobe at an edge where not all chip enables are active deselects the device. Drive-enable turns off at that edge. The processor strobe is not recognized while `en0_n` is high.
- R12: Burst addresses keep the upper address bits. The low two bits come from base+step in linear mode (`burst_linear`=1) or from base XOR step in interleaved mode (`burst_linear`=0). The step starts at 0 on a strobe, advances by one (mod 4) on a continuation edge with `adv_n`=0, and holds when `adv_n`=1.
- R13: While the device is selected, an edge with no recognized strobe continues the access at the burst address. It is a write when write controls are active and a read otherwise, and its drive-enable is live after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| addr_i | input | AW | Word address captured on a strobe |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| en0_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*9 | Write data: data bits [31:0], parity [35:32] |
| rdata_o | output | LANES*9 | Registered read data, same layout |
| drive_en_o | output | 1 | Bus drive enable for the data pins |

## Verification
A corrupted burst base or step register shows as the wrong word on `rdata_o` one edge after the next continuation read. Linear and interleaved runs from an odd base tell the two orders apart within four edges. A stale selected flag shows as `drive_en_o` rising on the cycle right after a read from idle, when it should stay low. A lost deselect shows as drive staying on one cycle too long. A lane-mask error stays hidden in the array until that address is read back, which is one strobe edge plus one edge later. The random phase checks every cycle's output against a bench model of the array, so any such error shows within a few cycles.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  // Kind of access decoded at one rising edge.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_DESEL = 2'd3
  } cyc_kind_e;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       linear);
    return linear ? (base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
  import sbw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             en0_n,
  input  logic             en1,
  input  logic             en2_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             active,
  output cyc_kind_e        kind,
  output logic             load,
  output logic             cont,
  output logic [LANES-1:0] lane_we
);

  logic             all_en;
  logic             cpu_seen;
  logic             any_strobe;
  logic [LANES-1:0] wmask;

  always_comb begin
    all_en     = !en0_n && en1 && !en2_n;
    cpu_seen   = !strobe_cpu_n && !en0_n;
    any_strobe = cpu_seen || !strobe_ctl_n;
    if (!wr_all_n)          wmask = '1;
    else if (!wr_lane_en_n) wmask = ~lane_sel_n;
    else                    wmask = '0;

    kind    = CYC_IDLE;
    load    = 1'b0;
    cont    = 1'b0;
    lane_we = '0;

    if (any_strobe && !all_en) begin
      kind = CYC_DESEL;
    end else if (cpu_seen) begin
      // processor strobe: always a read, write controls ignored
      kind = CYC_READ;
      load = 1'b1;
    end else if (!strobe_ctl_n) begin
      load = 1'b1;
      if (|wmask) begin
        kind    = CYC_WRITE;
        lane_we = wmask;
      end else begin
        kind = CYC_READ;
      end
    end else if (active) begin
      cont = 1'b1;
      if (|wmask) begin
        kind    = CYC_WRITE;
        lane_we = wmask;
      end else begin
        kind = CYC_READ;
      end
    end
  end

endmodule

// File: rtl/sbw_burst.sv
module sbw_burst
  import sbw_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          linear,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_use
);

  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  logic [1:0]    step_nx;

  assign step_nx  = load ? 2'd0 : (step_q + {1'b0, advance});
  assign addr_use = load ? addr_in
                         : {base_q[AW-1:2], burst_lo(base_q[1:0], step_nx, linear)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
    end else begin
      if (load) base_q <= addr_in;
      step_q <= step_nx;
    end
  end

endmodule

// File: rtl/sbw_lane_ram.sv
module sbw_lane_ram #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wword,
  input  logic                    rd,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rword
);

  localparam int DEPTH = 1 << AW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (we[k]) cells[waddr] <= wword[k*LANE_W +: LANE_W];
    end

    // read-first output register
    always_ff @(posedge clk) begin
      if (rst)     lane_q <= '0;
      else if (rd) lane_q <= cells[raddr];
    end

    assign rword[k*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sbw_sram.sv
module sbw_sram
  import sbw_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int BUS_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_linear,
  input  logic [AW-1:0]     addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              en2_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              drive_en_o
);

  cyc_kind_e        kind;
  logic             load;
  logic             cont;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    addr_use;
  logic [BUS_W-1:0] wlanes;
  logic [BUS_W-1:0] rlanes;

  logic             rd_q;
  logic [AW-1:0]    raddr_q;
  logic [LANES-1:0] we_q;
  logic [AW-1:0]    waddr_q;
  logic [BUS_W-1:0] wdata_q;
  logic             active_q;
  logic             live_q;

  sbw_decode #(.LANES(LANES)) u_decode (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .en0_n        (en0_n),
    .en1          (en1),
    .en2_n        (en2_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .active       (active_q),
    .kind         (kind),
    .load         (load),
    .cont         (cont),
    .lane_we      (lane_we)
  );

  sbw_burst #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .linear   (burst_linear),
    .load     (load),
    .advance  (cont && !adv_n),
    .addr_in  (addr_i),
    .addr_use (addr_use)
  );

  // bus layout (data low, parity high) <-> packed lanes
  for (genvar k = 0; k < LANES; k++) begin : g_pack
    assign wlanes[k*LANE_W +: LANE_W] = {wdata_i[DATA_W+k], wdata_i[k*BYTE_W +: BYTE_W]};
    assign rdata_o[k*BYTE_W +: BYTE_W] = rlanes[k*LANE_W +: BYTE_W];
    assign rdata_o[DATA_W+k]           = rlanes[k*LANE_W + BYTE_W];
  end

  // input stage: registered access, then array access one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      raddr_q  <= '0;
      we_q     <= '0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      active_q <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      rd_q    <= (kind == CYC_READ);
      raddr_q <= addr_use;
      we_q    <= lane_we;
      waddr_q <= addr_use;
      wdata_q <= wlanes;

      if (kind == CYC_DESEL) active_q <= 1'b0;
      else if (load)         active_q <= 1'b1;

      // first read out of deselect stays masked; writes and deselect blank
      live_q <= (kind == CYC_READ) && active_q;
    end
  end

  sbw_lane_ram #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (we_q),
    .waddr (waddr_q),
    .wword (wdata_q),
    .rd    (rd_q),
    .raddr (raddr_q),
    .rword (rlanes)
  );

  assign drive_en_o = live_q && !oe_n;

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int BUS_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe_cpu_n,
  input logic             strobe_ctl_n,
  input logic             en0_n,
  input logic             en1,
  input logic             en2_n,
  input logic             wr_all_n,
  input logic             oe_n,
  input logic             drive_en_o,
  input logic [BUS_W-1:0] rdata_o,
  input logic             rd_q,
  input logic             active_q
);

  logic all_en;
  logic seen;
  assign all_en = !en0_n && en1 && !en2_n;
  assign seen   = (!strobe_cpu_n && !en0_n) || !strobe_ctl_n;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rdata_o == '0 && !drive_en_o));

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_q |=> $stable(rdata_o));

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
    drive_en_o |-> !oe_n);

  assert_first_read_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !strobe_cpu_n && all_en) |=> !drive_en_o);

  // controller-strobe global write (R5) blanks the bus
  assert_write_blank_R10: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ctl_n && strobe_cpu_n && all_en && !wr_all_n) |=> !drive_en_o);

  assert_deselect_off_R11: assert property (@(posedge clk) disable iff (rst)
    (seen && !all_en) |=> (!drive_en_o && !active_q));

endmodule

bind sbw_sram sbw_checker #(.BUS_W(BUS_W)) u_sbw_checker (
  .clk          (clk),
  .rst          (rst),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .en0_n        (en0_n),
  .en1          (en1),
  .en2_n        (en2_n),
  .wr_all_n     (wr_all_n),
  .oe_n         (oe_n),
  .drive_en_o   (drive_en_o),
  .rdata_o      (rdata_o),
  .rd_q         (rd_q),
  .active_q     (active_q)
);

// File: tb/sbw_sram_bench.sv
`timescale 1ns/1ps
module sbw_sram_bench;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst;
  logic        burst_linear;
  logic [5:0]  addr_i;
  logic        strobe_cpu_n, strobe_ctl_n;
  logic        en0_n, en1, en2_n;
  logic        wr_all_n, wr_lane_en_n;
  logic [3:0]  lane_sel_n;
  logic        adv_n, oe_n;
  logic [35:0] wdata_i;
  logic [35:0] rdata_o;
  logic        drive_en_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  logic [35:0] mmem [DEPTH];
  logic [35:0] m_dout, m_pend_val;
  logic        m_pend, m_live, m_active;
  logic [5:0]  m_base;
  logic [1:0]  m_step;

  always #2 clk = ~clk;

  sbw_sram u_sbw_sram (
    .clk(clk), .rst(rst), .burst_linear(burst_linear), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
    .adv_n(adv_n), .oe_n(oe_n), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_en_o(drive_en_o)
  );

  function automatic logic [35:0] pat(input int a);
    logic [31:0] x;
    x = 32'h9E3779B9 * 32'(a) + 32'h12345678;
    return {x[3:0] ^ 4'(a), x};
  endfunction

  function automatic logic [1:0] exp_lo(input logic [1:0] b, input logic [1:0] s, input logic lin);
    return lin ? 2'(b + s) : (b ^ s);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic all_en, cpu_seen, strb, load, cont;
    logic [3:0] mask;
    logic [5:0] a;
    int kind;
    if (rst) begin
      m_dout = '0; m_live = 0; m_active = 0; m_pend = 0; m_base = '0; m_step = '0;
      return;
    end
    all_en   = !en0_n && en1 && !en2_n;
    cpu_seen = !strobe_cpu_n && !en0_n;
    strb     = cpu_seen || !strobe_ctl_n;
    mask     = !wr_all_n ? 4'hF : (!wr_lane_en_n ? ~lane_sel_n : 4'h0);
    load = 0; cont = 0;
    if (strb && !all_en)        kind = 3;
    else if (cpu_seen)          begin kind = 1; load = 1; end
    else if (!strobe_ctl_n)     begin kind = (mask != 0) ? 2 : 1; load = 1; end
    else if (m_active)          begin kind = (mask != 0) ? 2 : 1; cont = 1; end
    else                        kind = 0;
    if (load) begin
      a = addr_i; m_base = addr_i; m_step = 2'd0;
    end else begin
      if (cont && !adv_n) m_step = m_step + 2'd1;
      a = {m_base[5:2], exp_lo(m_base[1:0], m_step, burst_linear)};
    end
    if (m_pend) m_dout = m_pend_val;
    m_pend = (kind == 1);
    if (kind == 1) m_pend_val = mmem[a];
    if (kind == 2) begin
      for (int k = 0; k < 4; k++) begin
        if (mask[k]) begin
          mmem[a][k*8 +: 8] = wdata_i[k*8 +: 8];
          mmem[a][32+k]     = wdata_i[32+k];
        end
      end
    end
    m_live = (kind == 1) && m_active;
    if (kind == 3)  m_active = 0;
    else if (load)  m_active = 1;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " rdata"}, 64'(rdata_o), 64'(m_dout));
    chk({tag, " drive"}, 64'(drive_en_o), 64'(m_live && !oe_n));
  endtask

  task automatic set_idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1;
    en0_n = 0; en1 = 1; en2_n = 0;
    wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = 4'hF;
    adv_n = 1; oe_n = 0;
  endtask

  task automatic cpu_read(input int a);
    set_idle(); strobe_cpu_n = 0; addr_i = 6'(a);
    step("R3 cpu read");
  endtask

  task automatic burst_run(input logic lin, input int e0, input int e1, input int e2, input int e3);
    int exp_a [4];
    exp_a = '{e0, e1, e2, e3};
    burst_linear = lin;
    cpu_read(17);
    for (int i = 0; i < 4; i++) begin
      set_idle(); adv_n = (i == 3);
      step("R12 beat");
      chk(lin ? "R12 linear order" : "R12 interleaved order",
          64'(rdata_o), 64'(pat(exp_a[i])));
    end
    set_idle();
    step("R12 hold");
    chk("R12 adv high holds", 64'(rdata_o), 64'(pat(exp_a[3])));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [35:0] e;
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    rst = 1; burst_linear = 1; addr_i = '0; wdata_i = '0;
    set_idle();
    for (int i = 0; i < 3; i++) step("R1 reset");
    rst = 0;
    chk("R1 rdata after reset", 64'(rdata_o), 64'd0);
    chk("R1 drive after reset", 64'(drive_en_o), 64'd0);

    // fill the array with single-edge controller writes
    for (int a = 0; a < DEPTH; a++) begin
      set_idle(); strobe_ctl_n = 0; addr_i = 6'(a); wdata_i = pat(a); wr_all_n = 0;
      step("R5 fill");
      mmem[a] = pat(a);
    end

    // deselect, then read from idle
    set_idle(); strobe_ctl_n = 0; en1 = 0;
    step("R11");
    chk("R11 deselect blanks", 64'(drive_en_o), 64'd0);
    cpu_read(5);
    chk("R9 first read masked", 64'(drive_en_o), 64'd0);
    set_idle();
    step("R13 continue");
    chk("R2 read latency", 64'(rdata_o), 64'(pat(5)));
    chk("R9 drive after first cycle", 64'(drive_en_o), 64'd1);

    // asynchronous output enable
    oe_n = 1; #0.5;
    chk("R8 oe high blanks", 64'(drive_en_o), 64'd0);
    oe_n = 0; #0.5;
    chk("R8 oe low drives", 64'(drive_en_o), 64'd1);

    // processor strobe with en0_n high is ignored
    set_idle(); strobe_cpu_n = 0; en0_n = 1; addr_i = 6'd40;
    step("R11 ignored");
    chk("R11 cpu strobe ignored, drive", 64'(drive_en_o), 64'd1);
    chk("R11 cpu strobe ignored, data", 64'(rdata_o), 64'(pat(5)));

    // global write over deasserted lane selects
    set_idle(); strobe_ctl_n = 0; addr_i = 6'd7; wr_all_n = 0; wdata_i = 36'h1_2345_6789;
    step("R6 write");
    chk("R10 write blanks drive", 64'(drive_en_o), 64'd0);
    cpu_read(7); set_idle(); step("R6 read");
    chk("R6 global write", 64'(rdata_o), 64'h1_2345_6789);

    // single-lane write, lane 2
    set_idle(); strobe_ctl_n = 0; addr_i = 6'd8; wr_lane_en_n = 0; lane_sel_n = 4'b1011;
    wdata_i = 36'hF_FFFF_FFFF;
    step("R7 write");
    cpu_read(8); set_idle(); step("R7 read");
    e = pat(8); e[23:16] = 8'hFF; e[34] = 1'b1;
    chk("R7 lane 2 only", 64'(rdata_o), 64'(e));

    // selects low but byte-write enable high: read
    set_idle(); strobe_ctl_n = 0; addr_i = 6'd9; lane_sel_n = 4'h0; wdata_i = 36'h0;
    step("R3 ctl read");
    chk("R3 ctl read keeps drive", 64'(drive_en_o), 64'd1);
    set_idle(); step("R3 next");
    chk("R3 no write done", 64'(rdata_o), 64'(pat(9)));

    // processor strobe ignores write controls on its first edge
    set_idle(); strobe_cpu_n = 0; addr_i = 6'd11; wr_all_n = 0; adv_n = 0; wdata_i = 36'h0;
    step("R4 first");
    set_idle(); step("R4 next");
    chk("R4 first edge not a write", 64'(rdata_o), 64'(pat(11)));

    // two-edge write
    cpu_read(10);
    set_idle(); wr_all_n = 0; wdata_i = 36'hA_BCDE_F012;
    step("R4 second");
    chk("R10 second-edge write blanks", 64'(drive_en_o), 64'd0);
    cpu_read(10); set_idle(); step("R4 read");
    chk("R4 two-edge write", 64'(rdata_o), 64'hA_BCDE_F012);

    // both strobes: processor wins
    set_idle(); strobe_cpu_n = 0; strobe_ctl_n = 0; addr_i = 6'd12; wr_all_n = 0; wdata_i = 36'h0;
    step("R5 both");
    set_idle(); step("R5 both next");
    chk("R5 processor strobe wins", 64'(rdata_o), 64'(pat(12)));

    // controller write ignores advance
    set_idle(); strobe_ctl_n = 0; addr_i = 6'd13; wr_all_n = 0; adv_n = 0; wdata_i = 36'h5_0505_0505;
    step("R5 adv");
    cpu_read(13); set_idle(); step("R5 adv read");
    chk("R5 advance ignored", 64'(rdata_o), 64'h5_0505_0505);

    // burst orders from base 17
    burst_run(1'b1, 17, 18, 19, 16);
    burst_run(1'b0, 17, 16, 19, 18);
    burst_linear = 1;

    // continuation write with advance
    cpu_read(20);
    set_idle(); wr_all_n = 0; adv_n = 0; wdata_i = 36'h0_DEAD_BEEF;
    step("R13 write");
    cpu_read(21); set_idle(); step("R13 read");
    chk("R13 burst write lands on next beat", 64'(rdata_o), 64'h0_DEAD_BEEF);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) burst_linear = ~burst_linear;
      strobe_cpu_n = ($urandom % 4) != 0;
      strobe_ctl_n = ($urandom % 4) != 0;
      en0_n        = ($urandom % 8) == 0;
      en1          = ($urandom % 8) != 0;
      en2_n        = ($urandom % 8) == 0;
      wr_all_n     = ($urandom % 4) != 0;
      wr_lane_en_n = 1'($urandom % 2);
      lane_sel_n   = 4'($urandom);
      adv_n        = 1'($urandom % 2);
      oe_n         = ($urandom % 6) == 0;
      addr_i       = 6'($urandom);
      wdata_i      = {4'($urandom), 32'($urandom)};
      step("R2 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule